// File: doc/BRIEF.md
# SPI Master Transfer Engine with Per-Select Timing

This block is an SPI master that moves one 8-bit word per request in SPI mode 0. SCK idles low, MOSI changes after SCK falls, and MISO is captured as SCK rises. It drives up to four active-low selects. Each select has its own timing profile with three values: a clock divisor, a setup delay from select assertion to the first SCK cycle, and a gap delay between back-to-back words while the select is held. One global switch delay keeps every select released for a while when the engine moves from one slave to another. The right profile is applied automatically from the request's target select, so software never has to reprogram the engine between peripherals.

A client presents a target select, a data word and a keep flag on a request port. The request is taken in any cycle where the engine is idle. Busy then stays high until a one-cycle done pulse, and the received word is valid in the done cycle. If the keep flag is set, the select stays low after the word. If the next request targets that same select, only the gap delay is inserted before clocking resumes. A request that targets a select whose divisor is zero is refused: the engine raises an error pulse and starts nothing.

Top module: `spi_sel_master`

## Requirements
- R1: After reset all selects are high, SCK is low, and busy, done and err are low.
- R2: The request word is driven on MOSI most significant bit first. Each bit is stable across the rising SCK edge, and SCK is low whenever busy is low.
- R3: MISO is captured on each rising SCK edge, MSB first. The captured word appears on rxData in the done cycle.
- R4: With divisor D (bits [8s+7:8s] of cfgDiv for select s), each SCK half period lasts D system cycles. From the first rising SCK edge to done is 15·D cycles.
- R5: When a select is newly asserted, the first rising SCK edge follows the select's falling edge by setup+1+D cycles. The setup value is bits [8s+7:8s] of cfgSetup.
- R6: When a request targets the select still held low by a keep transfer, the select stays low. The first rising SCK edge comes gap+1+D cycles after acceptance, with gap taken from bits [8s+7:8s] of cfgGap.
- R7: When the target differs from the select of the previous transfer, all selects are high in the cycle after acceptance. The new select falls cfgSwitch+1 cycles after acceptance. The first transfer after reset skips this wait.
- R8: After done, the select stays low if the request's keep flag was 1 and all selects go high if it was 0. At most one select is ever low.
- R9: A request whose selected divisor is 0 causes a one-cycle err pulse in the next cycle. Busy stays low and the select lines stay unchanged.
- R10: Busy rises the cycle after acceptance and stays high through a single-cycle done pulse. Done comes pre+16·D cycles after acceptance. Here pre is gap+1 when the held select is reused, cfgSwitch+setup+2 when the select changes, and setup+1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken while busy is low |
| reqSel | input | 2 | Target select index |
| reqData | input | 8 | Word to transmit |
| reqKeep | input | 1 | Keep the select low after this word |
| cfgDiv | input | 32 | Per-select divisor, 8 bits per select |
| cfgSetup | input | 32 | Per-select assertion-to-clock delay |
| cfgGap | input | 32 | Per-select delay between held words |
| cfgSwitch | input | 8 | Global select-change delay |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | 8 | Received word, valid with done |
| err | output | 1 | One-cycle pulse for a refused request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | 4 | Active-low selects |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is the choice of delay path at acceptance. That choice depends on history: whether a select is still held by an earlier keep transfer, and which select was used last. The stimulus runs long request sequences in which the target select repeats in pairs and the keep flag follows a cycle of three. Every combination therefore occurs: held-and-same, held-and-different, released-and-same and released-and-different. These sequences run under several arithmetic mixes of setup, gap and switch values. A refused request is issued while another select is held, to show that the held select survives the error.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;    // capture the request word into the transmit register
    logic sample;  // take MISO into the receive register
    logic shift;   // present the next transmit bit
  } dpStrobe_t;
endpackage

// File: rtl/spi_sel_datapath.sv
module spi_sel_datapath
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (strb.load)
        txReg <= txData;
      else if (strb.shift)
        txReg <= {txReg[DATA_W-2:0], 1'b0};
      if (strb.sample)
        rxReg <= {rxReg[DATA_W-2:0], miso};
    end
  end

  assign mosi   = txReg[DATA_W-1];
  assign rxData = rxReg;
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl
  import spi_sel_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [SEL_W-1:0]        reqSel,
  input  logic                    reqKeep,
  input  logic [NUM_CS*CNT_W-1:0] cfgDiv,
  input  logic [NUM_CS*CNT_W-1:0] cfgSetup,
  input  logic [NUM_CS*CNT_W-1:0] cfgGap,
  input  logic [CNT_W-1:0]        cfgSwitch,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    sck,
  output logic [NUM_CS-1:0]       csN,
  output dpStrobe_t               strb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SWITCH, ST_SETUP, ST_GAP, ST_SHIFT, ST_FINISH
  } state_t;

  // Per-select profile fields unpacked from the flat configuration vectors
  logic [CNT_W-1:0] divArr   [NUM_CS];
  logic [CNT_W-1:0] setupArr [NUM_CS];
  logic [CNT_W-1:0] gapArr   [NUM_CS];
  for (genvar s = 0; s < NUM_CS; s++) begin : g_profile
    assign divArr[s]   = cfgDiv[s*CNT_W +: CNT_W];
    assign setupArr[s] = cfgSetup[s*CNT_W +: CNT_W];
    assign gapArr[s]   = cfgGap[s*CNT_W +: CNT_W];
  end

  state_t            state;
  logic [CNT_W-1:0]  dlyCnt;
  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W-1:0]  curDiv;
  logic [BIT_W-1:0]  bitCnt;
  logic [SEL_W-1:0]  curSel;
  logic [SEL_W-1:0]  lastSel;
  logic              lastValid;
  logic              held;
  logic              keepR;
  logic              sckR;
  logic              errR;
  logic [NUM_CS-1:0] csNR;

  logic accept;
  logic divOk;
  logic divEnd;
  logic lastBit;

  assign divOk   = (divArr[reqSel] != '0);
  assign accept  = (state == ST_IDLE) && reqValid;
  assign divEnd  = (divCnt == curDiv - CNT_W'(1));
  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));

  always_comb begin
    strb        = '0;
    strb.load   = accept && divOk;
    strb.sample = (state == ST_SHIFT) && divEnd && !sckR;
    strb.shift  = (state == ST_SHIFT) && divEnd && sckR && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dlyCnt    <= '0;
      divCnt    <= '0;
      curDiv    <= '0;
      bitCnt    <= '0;
      curSel    <= '0;
      lastSel   <= '0;
      lastValid <= 1'b0;
      held      <= 1'b0;
      keepR     <= 1'b0;
      sckR      <= 1'b0;
      errR      <= 1'b0;
      csNR      <= '1;
    end else begin
      errR <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          if (!divOk) begin
            errR <= 1'b1;
          end else begin
            curSel <= reqSel;
            curDiv <= divArr[reqSel];
            keepR  <= reqKeep;
            if (held && reqSel == lastSel) begin
              state  <= ST_GAP;
              dlyCnt <= gapArr[reqSel];
            end else if (lastValid && reqSel != lastSel) begin
              csNR   <= '1;
              held   <= 1'b0;
              state  <= ST_SWITCH;
              dlyCnt <= cfgSwitch;
            end else begin
              csNR         <= '1;
              csNR[reqSel] <= 1'b0;
              state        <= ST_SETUP;
              dlyCnt       <= setupArr[reqSel];
            end
          end
        end
        ST_SWITCH: begin
          if (dlyCnt == '0) begin
            csNR         <= '1;
            csNR[curSel] <= 1'b0;
            dlyCnt       <= setupArr[curSel];
            state        <= ST_SETUP;
          end else begin
            dlyCnt <= dlyCnt - CNT_W'(1);
          end
        end
        ST_SETUP, ST_GAP: begin
          if (dlyCnt == '0) begin
            state  <= ST_SHIFT;
            divCnt <= '0;
            bitCnt <= '0;
          end else begin
            dlyCnt <= dlyCnt - CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (divEnd) begin
            divCnt <= '0;
            if (!sckR) begin
              sckR <= 1'b1;
            end else begin
              sckR <= 1'b0;
              if (lastBit) state <= ST_FINISH;
              else bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            divCnt <= divCnt + CNT_W'(1);
          end
        end
        ST_FINISH: begin
          lastSel   <= curSel;
          lastValid <= 1'b1;
          held      <= keepR;
          if (!keepR) csNR <= '1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
  assign err  = errR;
  assign sck  = sckR;
  assign csN  = csNR;
endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master
  import spi_sel_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [SEL_W-1:0]        reqSel,
  input  logic [DATA_W-1:0]       reqData,
  input  logic                    reqKeep,
  input  logic [NUM_CS*CNT_W-1:0] cfgDiv,
  input  logic [NUM_CS*CNT_W-1:0] cfgSetup,
  input  logic [NUM_CS*CNT_W-1:0] cfgGap,
  input  logic [CNT_W-1:0]        cfgSwitch,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rxData,
  output logic                    err,
  output logic                    sck,
  output logic                    mosi,
  output logic [NUM_CS-1:0]       csN,
  input  logic                    miso
);
  dpStrobe_t strb;

  spi_sel_ctrl #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqKeep(reqKeep), .cfgDiv(cfgDiv), .cfgSetup(cfgSetup), .cfgGap(cfgGap),
    .cfgSwitch(cfgSwitch), .busy(busy), .done(done), .err(err), .sck(sck),
    .csN(csN), .strb(strb)
  );

  spi_sel_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(reqData), .miso(miso),
    .mosi(mosi), .rxData(rxData)
  );
endmodule

// File: rtl/spi_sel_master_chk.sv
module spi_sel_master_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sck,
  input logic [NUM_CS-1:0] csN
);
  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && !done));

  p_err_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(csN));

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  p_sck_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !(&csN));
endmodule

bind spi_sel_master spi_sel_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .sck(sck), .csN(csN)
);

// File: tb/spi_sel_master_test.sv
module spi_sel_master_test;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSel = '0;
  logic [7:0]  reqData = '0;
  logic        reqKeep = 1'b0;
  logic [31:0] cfgDiv = '0;
  logic [31:0] cfgSetup = '0;
  logic [31:0] cfgGap = '0;
  logic [7:0]  cfgSwitch = '0;
  logic        busy, done, err, sck, mosi, miso;
  logic [7:0]  rxData;
  logic [3:0]  csN;

  always #5 clk = ~clk;

  spi_sel_master uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel),
    .reqData(reqData), .reqKeep(reqKeep), .cfgDiv(cfgDiv), .cfgSetup(cfgSetup),
    .cfgGap(cfgGap), .cfgSwitch(cfgSwitch), .busy(busy), .done(done),
    .rxData(rxData), .err(err), .sck(sck), .mosi(mosi), .csN(csN), .miso(miso)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;

  // Slave model and edge monitor, sampled mid-cycle
  logic [7:0] slaveTx = '0;
  logic [7:0] slaveRx = '0;
  logic       prevSck = 1'b0;
  logic [3:0] prevCs = 4'hF;
  bit         gotRise = 1'b0;
  int         riseCyc = 0;
  int         csFallCyc = 0;
  assign miso = slaveTx[7];

  always @(negedge clk) begin
    if (sck && !prevSck) begin
      slaveRx = {slaveRx[6:0], mosi};
      if (!gotRise) begin gotRise = 1'b1; riseCyc = cyc; end
    end
    if (!sck && prevSck) slaveTx = {slaveTx[6:0], 1'b0};
    if ((prevCs & ~csN) != 4'h0) csFallCyc = cyc;
    prevSck = sck;
    prevCs  = csN;
  end

  // Bench-side profile and history model
  int  dv[NCS];
  int  su[NCS];
  int  gp[NCS];
  int  sw;
  bit  mHeld = 1'b0;
  bit  mLastValid = 1'b0;
  int  mLastSel = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyCfg();
    for (int s = 0; s < NCS; s++) begin
      cfgDiv[s*8 +: 8]   = 8'(dv[s]);
      cfgSetup[s*8 +: 8] = 8'(su[s]);
      cfgGap[s*8 +: 8]   = 8'(gp[s]);
    end
    cfgSwitch = 8'(sw);
  endtask

  task automatic doXfer(input int sel, input int data, input bit keep, input int tx);
    int  pre;
    int  acceptCyc;
    int  doneCyc;
    int  n;
    bit  sameHeld;
    bit  changing;
    logic [3:0] expCs;
    sameHeld = mHeld && (sel == mLastSel);
    changing = !sameHeld && mLastValid && (sel != mLastSel);
    if (sameHeld)      pre = gp[sel] + 1;
    else if (changing) pre = sw + su[sel] + 2;
    else               pre = su[sel] + 1;

    @(negedge clk);
    slaveTx = 8'(tx);
    slaveRx = '0;
    gotRise = 1'b0;
    csFallCyc = -1000;
    reqValid = 1'b1;
    reqSel   = 2'(sel);
    reqData  = 8'(data);
    reqKeep  = keep;
    @(posedge clk);
    @(negedge clk);
    acceptCyc = cyc;
    reqValid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    if (changing)
      chk(csN == 4'hF, "R7 selects released during switch", int'(csN), 15);
    if (sameHeld)
      chk(csN[sel] == 1'b0, "R6 held select stays low", int'(csN[sel]), 0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    doneCyc = cyc;
    chk(doneCyc - acceptCyc == pre + 16*dv[sel], "R10 done latency",
        doneCyc - acceptCyc, pre + 16*dv[sel]);
    chk(busy == 1'b1, "R10 busy with done", int'(busy), 1);
    if (sameHeld)
      chk(riseCyc - acceptCyc == pre + dv[sel], "R6 gap to first clock",
          riseCyc - acceptCyc, pre + dv[sel]);
    else if (changing)
      chk(riseCyc - acceptCyc == pre + dv[sel], "R7 switch to first clock",
          riseCyc - acceptCyc, pre + dv[sel]);
    if (!sameHeld)
      chk(riseCyc - csFallCyc == su[sel] + 1 + dv[sel], "R5 setup to first clock",
          riseCyc - csFallCyc, su[sel] + 1 + dv[sel]);
    chk(doneCyc - riseCyc == 15*dv[sel], "R4 clock half period",
        doneCyc - riseCyc, 15*dv[sel]);
    chk(slaveRx == 8'(data), "R2 MOSI word", int'(slaveRx), data & 255);
    chk(rxData == 8'(tx), "R3 received word", int'(rxData), tx & 255);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done single cycle",
        int'({done, busy}), 0);
    expCs = keep ? ~(4'b0001 << sel) : 4'hF;
    chk(csN == expCs, "R8 select after done", int'(csN), int'(expCs));
    mHeld = keep;
    mLastValid = 1'b1;
    mLastSel = sel;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 4'hF && sck == 1'b0, "R1 reset lines", int'({sck, csN}), 15);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset status",
        int'({busy, done, err}), 0);
    rstN = 1'b1;
    for (int v = 0; v < 3; v++) begin
      for (int s = 0; s < 3; s++) begin
        dv[s] = s + 1;
        su[s] = (s + v) % 3;
        gp[s] = (2*s + v) % 3;
      end
      dv[3] = 0; su[3] = 1; gp[3] = 1;
      sw = v;
      @(negedge clk);
      applyCfg();
      for (int k = 0; k < 24; k++) begin
        doXfer((k/2 + v) % 3, (k*37 + v*91 + 5) & 255, (k % 3) != 0,
               ((k*13) ^ 8'hA5) & 255);
      end
    end
    // Refused request on a zero divisor while select 0 is held
    doXfer(0, 8'h3C, 1'b1, 8'hC3);
    @(negedge clk);
    reqValid = 1'b1;
    reqSel   = 2'd3;
    reqData  = 8'h55;
    reqKeep  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(err == 1'b1, "R9 err pulse", int'(err), 1);
    chk(busy == 1'b0, "R9 no busy on refusal", int'(busy), 0);
    chk(csN == 4'hE, "R9 held select kept", int'(csN), 14);
    @(negedge clk);
    chk(err == 1'b0, "R9 err single cycle", int'(err), 0);
    chk(busy == 1'b0 && csN == 4'hE, "R9 state unchanged",
        int'({busy, csN}), 14);
    doXfer(0, 8'h81, 1'b0, 8'h7E);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule